// File: doc/BRIEF.md
# Multi-Channel Memory Request Arbiter

This block lets a group of memory consumers, such as per-core load/store units, share a smaller pool of memory channels. Each consumer presents independent read and write requests, each with a valid, an address and, for writes, data. Each channel is a small state machine. An idle channel picks up a pending consumer that no other channel is serving. It forwards the request to its memory port and holds it there until memory answers. It then hands the read data or a write acknowledgement back to the consumer. When the consumer withdraws its request, the channel frees that consumer.

Channels are assigned in one combinational pass over a working copy of a registered busy mask. Lower-numbered channels choose first. Each claim marks its consumer busy at once, so a later channel in the same cycle cannot take the same consumer. Several requests can therefore start in one cycle without any double servicing.

Top module: `mem_channel_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, every `mem_rd_valid`, `mem_wr_valid`, `cons_rd_ready` and `cons_wr_ready` bit is 0. The busy mask is empty, so the first requests after reset are claimed as if nothing had ever been served.
- R2: In one clock edge, every idle channel may claim a pending consumer. The idle channels are taken in ascending channel index, and each claims the lowest-indexed consumer that has a valid request and is not busy. With all channels idle, channel k therefore serves the k-th lowest pending consumer.
- R3: A consumer is served by at most one channel at a time. The number of busy consumers always equals the number of channels that are not idle.
- R4: If a consumer asserts both read and write valid when it is claimed, the channel issues the read first. The write is claimed later, after the read has completed.
- R5: Once a request is issued, the channel holds its memory valid high, with address and write data unchanged, until the matching memory ready is seen. No consumer ready is given before that point.
- R6: After memory ready on a read, the channel drives `cons_rd_ready` and the captured read data for that consumer. It holds both until the consumer drops `cons_rd_valid`.
- R7: A write is passed to memory with its address and data. After memory ready, the channel drives `cons_wr_ready` for that consumer and holds it until the consumer drops `cons_wr_valid`.
- R8: When the consumer drops its valid, the channel returns to idle on that edge and the consumer becomes claimable again. Every request is eventually served.
- R9: Consumer c occupies bits `[c*ADDR_W +: ADDR_W]` of the consumer address buses and `[c*DATA_W +: DATA_W]` of the consumer data buses. Channel h occupies the same slices of the memory buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cons_rd_valid | input | NUM_CONSUMERS | Read request per consumer |
| cons_rd_addr | input | NUM_CONSUMERS*ADDR_W | Read address per consumer |
| cons_rd_ready | output | NUM_CONSUMERS | Read data available per consumer |
| cons_rd_data | output | NUM_CONSUMERS*DATA_W | Read data per consumer |
| cons_wr_valid | input | NUM_CONSUMERS | Write request per consumer |
| cons_wr_addr | input | NUM_CONSUMERS*ADDR_W | Write address per consumer |
| cons_wr_data | input | NUM_CONSUMERS*DATA_W | Write data per consumer |
| cons_wr_ready | output | NUM_CONSUMERS | Write done per consumer |
| mem_rd_valid | output | NUM_CHANNELS | Read request per channel |
| mem_rd_addr | output | NUM_CHANNELS*ADDR_W | Read address per channel |
| mem_rd_ready | input | NUM_CHANNELS | Memory read response per channel |
| mem_rd_data | input | NUM_CHANNELS*DATA_W | Memory read data per channel |
| mem_wr_valid | output | NUM_CHANNELS | Write request per channel |
| mem_wr_addr | output | NUM_CHANNELS*ADDR_W | Write address per channel |
| mem_wr_data | output | NUM_CHANNELS*DATA_W | Write data per channel |
| mem_wr_ready | input | NUM_CHANNELS | Memory write response per channel |

## Verification
Two things can happen in the same cycle: several idle channels claiming consumers, and one consumer being both read- and write-pending when its claim is decided. The bench sweeps every combination of read and write valids over four consumers and two channels. Memory is held stalled so the claims can be observed at the memory ports. The expected owner of each channel is derived arithmetically from the k-th lowest pending consumer, with read chosen over write. The bench then lets memory answer and follows each request through to release, comparing the returned data and the stored writes with values it computes itself.

// File: rtl/mca_pkg.sv
package mca_pkg;
  typedef enum logic [2:0] {
    CH_IDLE     = 3'd0,
    CH_RD_WAIT  = 3'd1,
    CH_WR_WAIT  = 3'd2,
    CH_RD_RELAY = 3'd3,
    CH_WR_RELAY = 3'd4
  } ch_state_e;
endpackage

// File: rtl/mca_rst_sync.sv
module mca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/mca_claim.sv
// Combinational claim pass: releases first, then channels in index order
// each take the lowest free pending consumer, marking it busy at once.
module mca_claim #(
  parameter int NC  = 4,
  parameter int NH  = 2,
  parameter int IDW = 2
) (
  input  logic [NC-1:0]     busy_q,
  input  logic [NC-1:0]     req,
  input  logic [NH-1:0]     ch_idle,
  input  logic [NH-1:0]     ch_release,
  input  logic [NH*IDW-1:0] ch_id,
  output logic [NC-1:0]     busy_d,
  output logic [NH-1:0]     grant,
  output logic [NH*IDW-1:0] grant_id
);
  logic [NC-1:0] work;
  logic          found;

  always_comb begin
    work     = busy_q;
    grant    = '0;
    grant_id = '0;
    found    = 1'b0;
    for (int h = 0; h < NH; h++) begin
      if (ch_release[h]) work[ch_id[h*IDW +: IDW]] = 1'b0;
    end
    for (int h = 0; h < NH; h++) begin
      found = 1'b0;
      if (ch_idle[h]) begin
        for (int c = 0; c < NC; c++) begin
          if (!found && req[c] && !work[c]) begin
            found                    = 1'b1;
            work[c]                  = 1'b1;
            grant[h]                 = 1'b1;
            grant_id[h*IDW +: IDW]   = IDW'(c);
          end
        end
      end
    end
    busy_d = work;
  end
endmodule

// File: rtl/mca_channel.sv
module mca_channel
  import mca_pkg::*;
#(
  parameter int NC  = 4,
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int IDW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [IDW-1:0]   grant_id,
  input  logic [NC-1:0]    cons_rd_valid,
  input  logic [NC*AW-1:0] cons_rd_addr,
  input  logic [NC-1:0]    cons_wr_valid,
  input  logic [NC*AW-1:0] cons_wr_addr,
  input  logic [NC*DW-1:0] cons_wr_data,
  input  logic             mem_rd_ready,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             mem_wr_ready,
  output logic             mem_rd_valid,
  output logic             mem_wr_valid,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             idle,
  output logic             release_o,
  output logic [IDW-1:0]   id_o,
  output logic             rd_relay,
  output logic             wr_relay,
  output logic [DW-1:0]    rdata_o
);
  ch_state_e      state_q, state_d;
  logic           load_en, cap_en, state_en;
  logic           pick_rd;
  logic [IDW-1:0] id_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;

  assign pick_rd = cons_rd_valid[grant_id];

  always_comb begin
    state_d   = state_q;
    load_en   = 1'b0;
    cap_en    = 1'b0;
    release_o = 1'b0;
    unique case (state_q)
      CH_IDLE: if (grant) begin
        load_en = 1'b1;
        state_d = pick_rd ? CH_RD_WAIT : CH_WR_WAIT;
      end
      CH_RD_WAIT: if (mem_rd_ready) begin
        cap_en  = 1'b1;
        state_d = CH_RD_RELAY;
      end
      CH_WR_WAIT: if (mem_wr_ready) state_d = CH_WR_RELAY;
      CH_RD_RELAY: if (!cons_rd_valid[id_q]) begin
        release_o = 1'b1;
        state_d   = CH_IDLE;
      end
      CH_WR_RELAY: if (!cons_wr_valid[id_q]) begin
        release_o = 1'b1;
        state_d   = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= CH_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      id_q    <= grant_id;
      addr_q  <= pick_rd ? cons_rd_addr[int'(grant_id)*AW +: AW]
                         : cons_wr_addr[int'(grant_id)*AW +: AW];
      wdata_q <= cons_wr_data[int'(grant_id)*DW +: DW];
    end
    if (cap_en) rdata_q <= mem_rd_data;
  end

  assign mem_rd_valid = (state_q == CH_RD_WAIT);
  assign mem_wr_valid = (state_q == CH_WR_WAIT);
  assign rd_relay     = (state_q == CH_RD_RELAY);
  assign wr_relay     = (state_q == CH_WR_RELAY);
  assign idle         = (state_q == CH_IDLE);
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign id_o         = id_q;
  assign rdata_o      = rdata_q;
endmodule

// File: rtl/mem_channel_arbiter.sv
module mem_channel_arbiter #(
  parameter int NUM_CONSUMERS = 4,
  parameter int NUM_CHANNELS  = 2,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CONSUMERS-1:0]        cons_rd_valid,
  input  logic [NUM_CONSUMERS*ADDR_W-1:0] cons_rd_addr,
  output logic [NUM_CONSUMERS-1:0]        cons_rd_ready,
  output logic [NUM_CONSUMERS*DATA_W-1:0] cons_rd_data,
  input  logic [NUM_CONSUMERS-1:0]        cons_wr_valid,
  input  logic [NUM_CONSUMERS*ADDR_W-1:0] cons_wr_addr,
  input  logic [NUM_CONSUMERS*DATA_W-1:0] cons_wr_data,
  output logic [NUM_CONSUMERS-1:0]        cons_wr_ready,
  output logic [NUM_CHANNELS-1:0]         mem_rd_valid,
  output logic [NUM_CHANNELS*ADDR_W-1:0]  mem_rd_addr,
  input  logic [NUM_CHANNELS-1:0]         mem_rd_ready,
  input  logic [NUM_CHANNELS*DATA_W-1:0]  mem_rd_data,
  output logic [NUM_CHANNELS-1:0]         mem_wr_valid,
  output logic [NUM_CHANNELS*ADDR_W-1:0]  mem_wr_addr,
  output logic [NUM_CHANNELS*DATA_W-1:0]  mem_wr_data,
  input  logic [NUM_CHANNELS-1:0]         mem_wr_ready
);
  localparam int NC  = NUM_CONSUMERS;
  localparam int NH  = NUM_CHANNELS;
  localparam int IDW = (NC > 1) ? $clog2(NC) : 1;

  logic              rst_sync_n;
  logic [NC-1:0]     busy_q, busy_d;
  logic              busy_en;
  logic [NH-1:0]     ch_idle, ch_busy, ch_release, grant, ch_rd_relay, ch_wr_relay;
  logic [NH*IDW-1:0] ch_id, grant_id;
  logic [NH*DATA_W-1:0] ch_rdata;

  mca_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  mca_claim #(.NC(NC), .NH(NH), .IDW(IDW)) u_claim (
    .busy_q(busy_q), .req(cons_rd_valid | cons_wr_valid), .ch_idle(ch_idle),
    .ch_release(ch_release), .ch_id(ch_id), .busy_d(busy_d),
    .grant(grant), .grant_id(grant_id)
  );

  assign busy_en = (busy_d != busy_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  for (genvar h = 0; h < NH; h++) begin : g_ch
    mca_channel #(.NC(NC), .AW(ADDR_W), .DW(DATA_W), .IDW(IDW)) u_ch (
      .clk(clk), .rst_n(rst_sync_n),
      .grant(grant[h]), .grant_id(grant_id[h*IDW +: IDW]),
      .cons_rd_valid(cons_rd_valid), .cons_rd_addr(cons_rd_addr),
      .cons_wr_valid(cons_wr_valid), .cons_wr_addr(cons_wr_addr),
      .cons_wr_data(cons_wr_data),
      .mem_rd_ready(mem_rd_ready[h]), .mem_rd_data(mem_rd_data[h*DATA_W +: DATA_W]),
      .mem_wr_ready(mem_wr_ready[h]),
      .mem_rd_valid(mem_rd_valid[h]), .mem_wr_valid(mem_wr_valid[h]),
      .mem_addr(mem_rd_addr[h*ADDR_W +: ADDR_W]),
      .mem_wdata(mem_wr_data[h*DATA_W +: DATA_W]),
      .idle(ch_idle[h]), .release_o(ch_release[h]), .id_o(ch_id[h*IDW +: IDW]),
      .rd_relay(ch_rd_relay[h]), .wr_relay(ch_wr_relay[h]),
      .rdata_o(ch_rdata[h*DATA_W +: DATA_W])
    );
    assign mem_wr_addr[h*ADDR_W +: ADDR_W] = mem_rd_addr[h*ADDR_W +: ADDR_W];
  end

  assign ch_busy = ~ch_idle;

  always_comb begin
    cons_rd_ready = '0;
    cons_rd_data  = '0;
    cons_wr_ready = '0;
    for (int h = 0; h < NH; h++) begin
      if (ch_rd_relay[h]) begin
        cons_rd_ready[ch_id[h*IDW +: IDW]] = 1'b1;
        cons_rd_data[int'(ch_id[h*IDW +: IDW])*DATA_W +: DATA_W] = ch_rdata[h*DATA_W +: DATA_W];
      end
      if (ch_wr_relay[h]) cons_wr_ready[ch_id[h*IDW +: IDW]] = 1'b1;
    end
  end
endmodule

// File: rtl/mca_checker.sv
module mca_checker #(
  parameter int NC = 4,
  parameter int NH = 2,
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] busy_q,
  input logic [NH-1:0] ch_busy,
  input logic [NH-1:0] mem_rd_valid,
  input logic [NH-1:0] mem_rd_ready,
  input logic [NH*AW-1:0] mem_rd_addr,
  input logic [NH-1:0] mem_wr_valid,
  input logic [NH-1:0] mem_wr_ready,
  input logic [NH*AW-1:0] mem_wr_addr,
  input logic [NH*DW-1:0] mem_wr_data,
  input logic [NC-1:0] cons_rd_valid,
  input logic [NC-1:0] cons_rd_ready,
  input logic [NC-1:0] cons_wr_valid,
  input logic [NC-1:0] cons_wr_ready
);
  assert_one_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_q) == $countones(ch_busy));

  for (genvar h = 0; h < NH; h++) begin : g_h
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid[h] && !mem_rd_ready[h] |=>
        mem_rd_valid[h] && $stable(mem_rd_addr[h*AW +: AW]));
    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid[h] && !mem_wr_ready[h] |=>
        mem_wr_valid[h] && $stable(mem_wr_addr[h*AW +: AW]) &&
        $stable(mem_wr_data[h*DW +: DW]));
  end

  for (genvar c = 0; c < NC; c++) begin : g_c
    assert_rd_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cons_rd_ready[c] && cons_rd_valid[c] |=> cons_rd_ready[c]);
    assert_wr_ready_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cons_wr_ready[c] && cons_wr_valid[c] |=> cons_wr_ready[c]);
  end
endmodule

bind mem_channel_arbiter mca_checker #(
  .NC(NUM_CONSUMERS), .NH(NUM_CHANNELS), .AW(ADDR_W), .DW(DATA_W)
) u_mca_checker (
  .clk(clk), .rst_n(rst_sync_n), .busy_q(busy_q), .ch_busy(ch_busy),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data),
  .cons_rd_valid(cons_rd_valid), .cons_rd_ready(cons_rd_ready),
  .cons_wr_valid(cons_wr_valid), .cons_wr_ready(cons_wr_ready)
);

// File: tb/mem_channel_arbiter_test.sv
module mem_channel_arbiter_test;
  localparam int NC = 4;
  localparam int NH = 2;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NC-1:0]    rd_v = '0, wr_v = '0;
  logic [NC*AW-1:0] rd_a = '0, wr_a = '0;
  logic [NC*DW-1:0] wr_d = '0;
  logic [NC-1:0]    cons_rd_ready, cons_wr_ready;
  logic [NC*DW-1:0] cons_rd_data;
  logic [NH-1:0]    mem_rd_valid, mem_wr_valid, mem_rd_ready, mem_wr_ready;
  logic [NH*AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [NH*DW-1:0] mem_rd_data, mem_wr_data;
  logic             mem_go = 1'b0;
  logic [DW-1:0]    store [256];

  int checks = 0;
  int errors = 0;

  mem_channel_arbiter #(.NUM_CONSUMERS(NC), .NUM_CHANNELS(NH), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cons_rd_valid(rd_v), .cons_rd_addr(rd_a), .cons_rd_ready(cons_rd_ready),
    .cons_rd_data(cons_rd_data),
    .cons_wr_valid(wr_v), .cons_wr_addr(wr_a), .cons_wr_data(wr_d),
    .cons_wr_ready(cons_wr_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready)
  );

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return DW'(a * 3 + 1);
  endfunction
  function automatic logic [AW-1:0] rda(input int p, input int c);
    return AW'(p * 7 + c * 37);
  endfunction
  function automatic logic [DW-1:0] wrd(input int p, input int c);
    return DW'(p * 5 + c * 11 + 3);
  endfunction

  // Memory model: answers at once when released by mem_go.
  assign mem_rd_ready = mem_go ? mem_rd_valid : '0;
  assign mem_wr_ready = mem_go ? mem_wr_valid : '0;
  always_comb begin
    for (int h = 0; h < NH; h++)
      mem_rd_data[h*DW +: DW] = mem_fn(mem_rd_addr[h*AW +: AW]);
  end
  always @(posedge clk) begin
    for (int h = 0; h < NH; h++)
      if (mem_wr_valid[h] && mem_wr_ready[h])
        store[mem_wr_addr[h*AW +: AW]] <= mem_wr_data[h*DW +: DW];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_claims(input int p, input logic [NC-1:0] rp, input logic [NC-1:0] wp,
                              input string tag);
    logic [NH-1:0] erv, ewv;
    logic [AW-1:0] ea [NH];
    logic [DW-1:0] ed [NH];
    int k;
    erv = '0; ewv = '0; k = 0;
    for (int h = 0; h < NH; h++) begin ea[h] = '0; ed[h] = '0; end
    for (int c = 0; c < NC; c++) begin
      if ((rp[c] || wp[c]) && k < NH) begin
        if (rp[c]) begin erv[k] = 1'b1; ea[k] = rda(p, c); end
        else begin ewv[k] = 1'b1; ea[k] = rda(p, c) ^ 8'h80; ed[k] = wrd(p, c); end
        k++;
      end
    end
    check({tag, " R2 R4 rd valids"}, 32'(mem_rd_valid), 32'(erv));
    check({tag, " R2 R4 wr valids"}, 32'(mem_wr_valid), 32'(ewv));
    for (int h = 0; h < NH; h++) begin
      if (erv[h] || ewv[h]) check({tag, " R3 R9 channel addr"}, 32'(mem_rd_addr[h*AW +: AW]), 32'(ea[h]));
      if (ewv[h]) check({tag, " R7 wr data"}, 32'(mem_wr_data[h*DW +: DW]), 32'(ed[h]));
    end
  endtask

  task automatic run_pattern(input int p, input logic [NC-1:0] rp, input logic [NC-1:0] wp);
    int cyc;
    @(negedge clk);
    mem_go = 1'b0;
    for (int c = 0; c < NC; c++) begin
      rd_a[c*AW +: AW] = rda(p, c);
      wr_a[c*AW +: AW] = rda(p, c) ^ 8'h80;
      wr_d[c*DW +: DW] = wrd(p, c);
    end
    rd_v = rp; wr_v = wp;
    @(posedge clk); @(negedge clk);
    check_claims(p, rp, wp, "first edge");
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_claims(p, rp, wp, "R5 stalled");
    check("R5 no ready while stalled", 32'(cons_rd_ready | cons_wr_ready), 32'd0);
    mem_go = 1'b1;
    cyc = 0;
    while ((rd_v | wr_v) != '0 && cyc < 60) begin
      for (int c = 0; c < NC; c++) begin
        if (rd_v[c] && cons_rd_ready[c]) begin
          check("R6 read data", 32'(cons_rd_data[c*DW +: DW]), 32'(mem_fn(rda(p, c))));
          rd_v[c] = 1'b0;
        end
        if (wr_v[c] && cons_wr_ready[c]) begin
          check("R7 stored write", 32'(store[rda(p, c) ^ 8'h80]), 32'(wrd(p, c)));
          wr_v[c] = 1'b0;
        end
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    check("R8 all requests served", 32'(rd_v | wr_v), 32'd0);
    rd_v = '0; wr_v = '0;
    @(posedge clk); @(negedge clk);
    check("R8 channels idle", 32'(mem_rd_valid | mem_wr_valid), 32'd0);
    check("R8 readies dropped", 32'(cons_rd_ready | cons_wr_ready), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 mem valids in reset", 32'(mem_rd_valid | mem_wr_valid), 32'd0);
    check("R1 readies in reset", 32'(cons_rd_ready | cons_wr_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 mem valids after reset", 32'(mem_rd_valid | mem_wr_valid), 32'd0);
    for (int rp = 0; rp < 16; rp++)
      for (int wp = 0; wp < 16; wp++)
        run_pattern(rp * 16 + wp, NC'(rp), NC'(wp));
    // Reset in the middle of service, then fresh claims.
    @(negedge clk);
    mem_go = 1'b0;
    rd_v = '1;
    @(posedge clk); @(negedge clk);
    check("R2 busy before reset", 32'(mem_rd_valid), 32'h3);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", 32'(mem_rd_valid | mem_wr_valid), 32'd0);
    rd_v = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run_pattern(3, 4'b1111, 4'b0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule